// File: doc/BRIEF.md
# Indirect Address Register Unit

This unit keeps a small bank of address registers together with a pointer that names the register currently in use. A strobed operation can load the pointer, load any register with an immediate address, perform an indirect access, or evaluate a loop condition. An indirect access presents the pointed register as a data-memory address. In the same step the access can leave that register unchanged, step it up by one or step it down by one, and it can also move the pointer to another register. Walking a source buffer and a destination buffer in turn then needs no separate pointer instructions.

The loop operation reports whether the pointed register is non-zero and decrements it in the same step. Loop counting and pointer switching can therefore share one operation at the end of a loop body. Results appear one cycle after the strobe on registered outputs. Any register can be read back at any time through a separate index, and the pointer is also visible on an output. The unit contains neither the memory nor the instruction decoder.

Top module: `arau_top`

## Requirements
- R1: After reset all registers read zero, the pointer is zero, and `addr_vld` and `br_vld` are low.
- R2: With `op_stb` high and `op_code` = 2 (register load), register `op_idx` takes `op_imm` at the clock edge. `rd_data` shows register `rd_idx` combinationally.
- R3: With `op_stb` high and `op_code` = 1 (pointer load), the pointer takes `op_idx` at the clock edge and appears on `ptr_q`.
- R4: An access (`op_code` 3 = keep, 4 = post-increment, 5 = post-decrement) raises `addr_vld` for exactly one cycle after the strobe edge. During that cycle `eff_addr` holds the pointed register's value from before the modification.
- R5: A post-increment adds one to the pointed register and a post-decrement subtracts one, both modulo 2^16 (FFFF+1 = 0, 0-1 = FFFF). A keep access leaves the register unchanged.
- R6: When `ptr_upd` is high during an access or loop operation, the pointer becomes `op_idx`. The modification applies to the register named by the old pointer, and the new pointer is used from the next operation on.
- R7: A loop operation (`op_code` = 6) raises `br_vld` for one cycle after the strobe edge. During that cycle `br_taken` is 1 exactly when the pointed register was non-zero before the operation.
- R8: A loop operation always decrements the pointed register, wrapping 0 to FFFF, even when the branch is not taken.
- R9: With `op_stb` low, no register, the pointer, `addr_vld` or `br_vld` changes, whatever the other inputs hold.
- R10: Op codes 0 and 7 under a strobe change neither the registers nor the pointer and raise neither valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_stb | input | 1 | Operation strobe |
| op_code | input | 3 | Operation code |
| op_idx | input | 3 | Register index for loads; new pointer value otherwise |
| op_imm | input | 16 | Immediate address for register load |
| ptr_upd | input | 1 | Move the pointer to `op_idx` during access or loop |
| rd_idx | input | 3 | Readback register select |
| rd_data | output | 16 | Readback register value |
| ptr_q | output | 3 | Current pointer |
| eff_addr | output | 16 | Effective address of the last access |
| addr_vld | output | 1 | Access result valid |
| br_vld | output | 1 | Loop result valid |
| br_taken | output | 1 | Loop branch condition |

## Verification
The hardest case to reach is an operation that changes one register and the pointer in the same edge. The old register must take the modification while the next access must already see the new register. The stimulus reproduces this with a buffer-copy loop. The loop alternates post-increment accesses between a source register and a destination register, each one switching the pointer. It closes with a loop test on a counter register that switches back to the source. The counter runs past zero so that both branch outcomes occur and the decrement wraps. The scoreboard model keeps its own pointer and bank, and readback afterwards confirms which register took each modification.

// File: rtl/arau_pkg.sv
package arau_pkg;
   typedef enum logic [2:0] {
      OP_NOP    = 3'd0,
      OP_LDPTR  = 3'd1,
      OP_LDREG  = 3'd2,
      OP_ACC    = 3'd3,
      OP_ACCINC = 3'd4,
      OP_ACCDEC = 3'd5,
      OP_LOOP   = 3'd6,
      OP_RSV    = 3'd7
   } arau_op_e;

   typedef enum logic [1:0] {
      STEP_KEEP = 2'd0,
      STEP_INC  = 2'd1,
      STEP_DEC  = 2'd2
   } arau_step_e;
endpackage

// File: rtl/arau_step.sv
module arau_step #(
   parameter int AW = 16
) (
   input  arau_pkg::arau_step_e mode,
   input  logic [AW-1:0]        val,
   output logic [AW-1:0]        nxt
);
   import arau_pkg::*;
   localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

   always_comb begin
      unique case (mode)
         STEP_INC: nxt = val + ONE;
         STEP_DEC: nxt = val - ONE;
         default:  nxt = val;
      endcase
   end
endmodule

// File: rtl/arau_ptr.sv
module arau_ptr #(
   parameter int PW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [PW-1:0] new_val,
   output logic [PW-1:0] ptr_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    ptr_q <= '0;
      else if (load) ptr_q <= new_val;
   end

   // R3
   ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ptr_q == $past(new_val));

   // R9
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(ptr_q));
endmodule

// File: rtl/arau_regfile.sv
module arau_regfile #(
   parameter int NUM_REGS = 8,
   parameter int AW       = 16,
   localparam int PW      = $clog2(NUM_REGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [PW-1:0] wr_idx,
   input  logic [AW-1:0] wr_data,
   input  logic [PW-1:0] cur_idx,
   output logic [AW-1:0] cur_val,
   input  logic [PW-1:0] rd_idx,
   output logic [AW-1:0] rd_data
);
   logic [AW-1:0] bank [NUM_REGS];

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            bank[gi] <= '0;
         else if (wr_en && wr_idx == PW'(gi))
            bank[gi] <= wr_data;
      end
   end

   assign cur_val = bank[cur_idx];
   assign rd_data = bank[rd_idx];

   // R2
   wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> bank[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/arau_top.sv
module arau_top #(
   parameter int NUM_REGS = 8,
   parameter int AW       = 16,
   localparam int PW      = $clog2(NUM_REGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_stb,
   input  logic [2:0]    op_code,
   input  logic [PW-1:0] op_idx,
   input  logic [AW-1:0] op_imm,
   input  logic          ptr_upd,
   input  logic [PW-1:0] rd_idx,
   output logic [AW-1:0] rd_data,
   output logic [PW-1:0] ptr_q,
   output logic [AW-1:0] eff_addr,
   output logic          addr_vld,
   output logic          br_vld,
   output logic          br_taken
);
   import arau_pkg::*;

   if (NUM_REGS < 2 || NUM_REGS != (1 << PW)) begin : g_bad_regs
      $error("NUM_REGS must be a power of two of at least 2");
   end
   if (AW < 2) begin : g_bad_aw
      $error("AW must be at least 2");
   end

   logic          do_ldptr, do_ldreg, do_acc, do_loop;
   arau_step_e    step_mode;
   logic [AW-1:0] cur_val, step_val;
   logic          wr_en;
   logic [PW-1:0] wr_idx;
   logic [AW-1:0] wr_data;
   logic          ptr_load;
   logic [PW-1:0] ptr_new;

   always_comb begin
      do_ldptr  = op_stb && (op_code == OP_LDPTR);
      do_ldreg  = op_stb && (op_code == OP_LDREG);
      do_acc    = op_stb && (op_code == OP_ACC || op_code == OP_ACCINC ||
                             op_code == OP_ACCDEC);
      do_loop   = op_stb && (op_code == OP_LOOP);
      step_mode = STEP_KEEP;
      if (op_code == OP_ACCINC)                           step_mode = STEP_INC;
      else if (op_code == OP_ACCDEC || op_code == OP_LOOP) step_mode = STEP_DEC;
   end

   arau_step #(.AW(AW)) u_step (
      .mode (step_mode),
      .val  (cur_val),
      .nxt  (step_val)
   );

   assign wr_en   = do_ldreg || ((do_acc || do_loop) && step_mode != STEP_KEEP);
   assign wr_idx  = do_ldreg ? op_idx : ptr_q;
   assign wr_data = do_ldreg ? op_imm : step_val;

   arau_regfile #(.NUM_REGS(NUM_REGS), .AW(AW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .cur_idx (ptr_q),
      .cur_val (cur_val),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   assign ptr_load = do_ldptr || ((do_acc || do_loop) && ptr_upd);
   assign ptr_new  = op_idx;

   arau_ptr #(.PW(PW)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ptr_load),
      .new_val (ptr_new),
      .ptr_q   (ptr_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eff_addr <= '0;
         addr_vld <= 1'b0;
         br_vld   <= 1'b0;
         br_taken <= 1'b0;
      end else begin
         addr_vld <= do_acc;
         br_vld   <= do_loop;
         br_taken <= do_loop && (cur_val != '0);
         if (do_acc) eff_addr <= cur_val;
      end
   end

   // R4
   addr_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_acc |=> addr_vld && eff_addr == $past(cur_val));

   // R5
   inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_stb && op_code == OP_ACCINC && !ptr_upd) |=> cur_val == $past(cur_val) + 1'b1);

   // R7
   br_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_loop |=> br_vld && (br_taken == ($past(cur_val) != '0)));

   // R9
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_stb |=> !addr_vld && !br_vld);

   // R4 R7
   excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(addr_vld && br_vld));
endmodule

// File: tb/arau_top_test.sv
`timescale 1ns/1ps
module arau_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_stb = 1'b0;
   logic [2:0]  op_code = '0;
   logic [2:0]  op_idx = '0;
   logic [15:0] op_imm = '0;
   logic        ptr_upd = 1'b0;
   logic [2:0]  rd_idx = '0;
   logic [15:0] rd_data, eff_addr;
   logic [2:0]  ptr_q;
   logic        addr_vld, br_vld, br_taken;

   int n_vec = 0;
   int n_bad = 0;

   bit          q_kind [$];
   logic [15:0] q_val  [$];
   string       q_tag  [$];

   logic [15:0] m_reg [8];
   logic [2:0]  m_ptr;

   always #2.5 clk = ~clk;

   arau_top uut (
      .clk(clk), .rst_n(rst_n), .op_stb(op_stb), .op_code(op_code),
      .op_idx(op_idx), .op_imm(op_imm), .ptr_upd(ptr_upd), .rd_idx(rd_idx),
      .rd_data(rd_data), .ptr_q(ptr_q), .eff_addr(eff_addr),
      .addr_vld(addr_vld), .br_vld(br_vld), .br_taken(br_taken)
   );

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected results as outputs become valid
   always @(negedge clk) begin
      if (rst_n && (addr_vld || br_vld)) begin
         if (q_kind.size() == 0) begin
            check("R9 unexpected result", {14'd0, addr_vld, br_vld}, 16'd0);
         end else begin
            automatic bit          k = q_kind.pop_front();
            automatic logic [15:0] v = q_val.pop_front();
            automatic string       t = q_tag.pop_front();
            if (k) begin
               check({t, " kind"}, {15'd0, br_vld}, 16'd1);
               check(t, {15'd0, br_taken}, v);
            end else begin
               check({t, " kind"}, {15'd0, addr_vld}, 16'd1);
               check(t, eff_addr, v);
            end
         end
      end
   end

   task automatic drive(logic [2:0] code, logic [2:0] idx, logic [15:0] imm,
                        bit upd, string tag);
      logic [2:0] cur;
      @(negedge clk);
      op_stb = 1'b1; op_code = code; op_idx = idx; op_imm = imm; ptr_upd = upd;
      cur = m_ptr;
      case (code)
         3'd1: m_ptr = idx;
         3'd2: m_reg[idx] = imm;
         3'd3, 3'd4, 3'd5: begin
            q_kind.push_back(1'b0); q_val.push_back(m_reg[cur]); q_tag.push_back(tag);
            if (code == 3'd4) m_reg[cur] = m_reg[cur] + 16'd1;
            if (code == 3'd5) m_reg[cur] = m_reg[cur] - 16'd1;
            if (upd) m_ptr = idx;
         end
         3'd6: begin
            q_kind.push_back(1'b1); q_val.push_back({15'd0, m_reg[cur] != 16'd0});
            q_tag.push_back(tag);
            m_reg[cur] = m_reg[cur] - 16'd1;
            if (upd) m_ptr = idx;
         end
         default: ;
      endcase
      @(posedge clk);
      #1 op_stb = 1'b0;
   endtask

   task automatic audit(string tag);
      @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rd_idx = 3'(i);
         #0.1;
         check({tag, " reg"}, rd_data, m_reg[i]);
      end
      check({tag, " ptr"}, {13'd0, ptr_q}, {13'd0, m_ptr});
   endtask

   initial begin
      #100000;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) m_reg[i] = '0;
      m_ptr = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 addr_vld", {15'd0, addr_vld}, 16'd0);
      check("R1 br_vld", {15'd0, br_vld}, 16'd0);
      audit("R1");

      // R2 register loads
      drive(3'd2, 3'd1, 16'h0820, 0, "R2");
      drive(3'd2, 3'd2, 16'h0100, 0, "R2");
      drive(3'd2, 3'd0, 16'h0003, 0, "R2");
      drive(3'd2, 3'd7, 16'hFFFF, 0, "R2");
      drive(3'd2, 3'd4, 16'h074F, 0, "R2");
      audit("R2");

      // R3 pointer load, R4/R5 modify and wrap
      drive(3'd1, 3'd7, 16'h0000, 0, "R3");
      audit("R3");
      drive(3'd4, 3'd0, 16'h0, 0, "R4 inc addr");
      drive(3'd5, 3'd0, 16'h0, 0, "R4 dec addr");
      drive(3'd3, 3'd0, 16'h0, 0, "R4 keep addr");
      audit("R5 wrap");

      // R6 modify old reg while switching pointer
      drive(3'd1, 3'd2, 16'h0, 0, "R3");
      drive(3'd4, 3'd4, 16'h0, 1, "R6 old reg");
      drive(3'd3, 3'd0, 16'h0, 0, "R6 new reg");
      audit("R6");

      // R6/R7/R8 buffer copy loop on counter in reg 0
      drive(3'd1, 3'd1, 16'h0, 0, "R3");
      for (int it = 0; it < 4; it++) begin
         drive(3'd4, 3'd2, 16'h0, 1, "R6 src");
         drive(3'd4, 3'd0, 16'h0, 1, "R6 dst");
         drive(3'd6, 3'd1, 16'h0, 1, "R7 loop");
      end
      audit("R8 copy");

      // R8 loop on zero register
      drive(3'd2, 3'd5, 16'h0000, 0, "R2");
      drive(3'd1, 3'd5, 16'h0, 0, "R3");
      drive(3'd6, 3'd0, 16'h0, 0, "R7 zero");
      audit("R8 zero wrap");

      // R9 no strobe: inputs ignored
      @(negedge clk);
      op_stb = 1'b0; op_code = 3'd2; op_idx = 3'd3; op_imm = 16'hBEEF; ptr_upd = 1'b1;
      @(negedge clk);
      op_code = 3'd1; op_idx = 3'd6;
      @(negedge clk);
      op_code = 3'd6;
      @(negedge clk);
      check("R9 addr_vld", {15'd0, addr_vld}, 16'd0);
      check("R9 br_vld", {15'd0, br_vld}, 16'd0);
      audit("R9");

      // R10 reserved codes
      drive(3'd0, 3'd3, 16'h1234, 1, "R10");
      drive(3'd7, 3'd6, 16'h5678, 1, "R10");
      @(negedge clk);
      check("R10 addr_vld", {15'd0, addr_vld}, 16'd0);
      check("R10 br_vld", {15'd0, br_vld}, 16'd0);
      audit("R10");

      repeat (3) @(negedge clk);
      check("R4 R7 queue drained", 16'(q_kind.size()), 16'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule